// File: doc/BRIEF.md
# Integer Execute Unit with Function-Code Decode

This block is the combinational integer execute stage of a 32-bit, three-operand, load/store processor. The decode stage hands it the raw instruction fields and both register read values. These fields are the 6-bit primary opcode, the 6-bit function code, the 5-bit shift count and the 16-bit immediate. In the same cycle the block returns a 32-bit result and a flag that marks an unsupported encoding.

It decodes the register-form instructions from the function code when the opcode is all zeros, and the immediate-form instructions from the opcode. The immediate forms use the immediate field in place of the second register. That field is sign-extended or zero-extended according to the class of the operation. Shifts always act on the second register operand. The shift count comes either from the 5-bit shift field or from the low five bits of the first register. There is no clock, no state and no reset.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 000000, function 100000 gives rs + rt modulo 2^32. Opcodes 001000 and 001001 give rs plus the sign-extended immediate, modulo 2^32.
- R2: With opcode 000000, function 100010 gives rs - rt modulo 2^32.
- R3: With opcode 000000, the bitwise operations are selected by function code: 100100 gives rs AND rt, 100101 gives rs OR rt, 100110 gives rs XOR rt, and 100111 gives NOT(rs OR rt).
- R4: Function 100010-free signed compare: with opcode 000000, function 101010 writes exactly 1 when rs < rt as two's-complement values and 0 otherwise. Opcode 001010 does the same against the sign-extended immediate.
- R5: With opcode 000000, function 101011 writes exactly 1 when rs < rt as unsigned values and 0 otherwise.
- R6: With opcode 000000, function 000000 shifts rt left and function 000010 shifts rt right, both by the shift field (0 to 31) and both filling with zeros.
- R7: With opcode 000000, function 000011 shifts rt right by the shift field and fills vacated bits with copies of rt bit 31. A count of 0 returns rt unchanged.
- R8: With opcode 000000, functions 000100 (left), 000110 (logical right) and 000111 (arithmetic right) shift rt by rs[4:0]. Bits 31..5 of rs and the shift field have no effect on these.
- R9: The immediate is sign-extended for opcodes 001000, 001001 and 001010. It is zero-extended for opcodes 001100 (AND), 001101 (OR) and 001110 (XOR).
- R10: Any opcode or function code not listed in R1 to R9 forces the result to 0 and raises the illegal flag. Every listed encoding keeps the flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function code, used when opcode is 000000 |
| shamt_i | input | 5 | Immediate shift count |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand, also the shift source |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Computed result |
| illegal_o | output | 1 | High for an unsupported encoding |

## Verification
The checks inside the block assume that all inputs hold known values. Whenever any input is unknown, they skip the evaluation. They also assume the inputs are stable when evaluated, because the block has no clock to qualify them. The stimulus drives every field on the falling edge of the bench clock and reads the outputs a nanosecond later. Random vectors mostly pick from the legal encodings. Operands are drawn either from full-range random values or from the sign-boundary values. A minority of vectors use random opcodes and function codes, so the illegal path is exercised.

// File: rtl/iex_pkg.sv
`timescale 1ns/1ps
package iex_pkg;

    localparam int DATA_W  = 32;
    localparam int SHAMT_W = 5;
    localparam int IMM_W   = 16;
    localparam int CODE_W  = 6;

    // primary opcodes
    localparam logic [CODE_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [CODE_W-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [CODE_W-1:0] OPC_ADDIU = 6'b001001;
    localparam logic [CODE_W-1:0] OPC_SLTI  = 6'b001010;
    localparam logic [CODE_W-1:0] OPC_ANDI  = 6'b001100;
    localparam logic [CODE_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [CODE_W-1:0] OPC_XORI  = 6'b001110;

    // function codes under OPC_REG
    localparam logic [CODE_W-1:0] FN_SLL  = 6'b000000;
    localparam logic [CODE_W-1:0] FN_SRL  = 6'b000010;
    localparam logic [CODE_W-1:0] FN_SRA  = 6'b000011;
    localparam logic [CODE_W-1:0] FN_SLLV = 6'b000100;
    localparam logic [CODE_W-1:0] FN_SRLV = 6'b000110;
    localparam logic [CODE_W-1:0] FN_SRAV = 6'b000111;
    localparam logic [CODE_W-1:0] FN_ADD  = 6'b100000;
    localparam logic [CODE_W-1:0] FN_SUB  = 6'b100010;
    localparam logic [CODE_W-1:0] FN_AND  = 6'b100100;
    localparam logic [CODE_W-1:0] FN_OR   = 6'b100101;
    localparam logic [CODE_W-1:0] FN_XOR  = 6'b100110;
    localparam logic [CODE_W-1:0] FN_NOR  = 6'b100111;
    localparam logic [CODE_W-1:0] FN_SLT  = 6'b101010;
    localparam logic [CODE_W-1:0] FN_SLTU = 6'b101011;

    typedef enum logic [3:0] {
        XOP_NONE,
        XOP_ADD,
        XOP_SUB,
        XOP_AND,
        XOP_OR,
        XOP_XOR,
        XOP_NOR,
        XOP_LTS,
        XOP_LTU,
        XOP_SHL,
        XOP_SHR,
        XOP_SHA
    } xop_e;

    typedef enum logic [1:0] {
        SHK_LEFT,
        SHK_RLOG,
        SHK_RARI
    } shk_e;

    typedef struct packed {
        xop_e op;
        logic bad;
        logic use_imm;
        logic imm_sext;
        logic var_shift;
    } xdec_t;

    function automatic logic [DATA_W-1:0] widen_imm(
        input logic [IMM_W-1:0] imm,
        input logic             sext
    );
        logic fill;
        fill = sext & imm[IMM_W-1];
        return {{(DATA_W-IMM_W){fill}}, imm};
    endfunction

    function automatic shk_e shift_kind(input xop_e op);
        case (op)
            XOP_SHR: return SHK_RLOG;
            XOP_SHA: return SHK_RARI;
            default: return SHK_LEFT;
        endcase
    endfunction

endpackage

// File: rtl/iex_decode.sv
`timescale 1ns/1ps
module iex_decode
    import iex_pkg::*;
(
    input  logic [CODE_W-1:0] opcode,
    input  logic [CODE_W-1:0] funct,
    output xdec_t             dec
);

    xdec_t reg_form;
    xdec_t imm_form;

    // register-form table, keyed on the function code
    always_comb begin
        reg_form = '{op: XOP_NONE, bad: 1'b0, use_imm: 1'b0,
                     imm_sext: 1'b0, var_shift: 1'b0};
        case (funct)
            FN_ADD:  reg_form.op = XOP_ADD;
            FN_SUB:  reg_form.op = XOP_SUB;
            FN_AND:  reg_form.op = XOP_AND;
            FN_OR:   reg_form.op = XOP_OR;
            FN_XOR:  reg_form.op = XOP_XOR;
            FN_NOR:  reg_form.op = XOP_NOR;
            FN_SLT:  reg_form.op = XOP_LTS;
            FN_SLTU: reg_form.op = XOP_LTU;
            FN_SLL:  reg_form.op = XOP_SHL;
            FN_SRL:  reg_form.op = XOP_SHR;
            FN_SRA:  reg_form.op = XOP_SHA;
            FN_SLLV: begin reg_form.op = XOP_SHL; reg_form.var_shift = 1'b1; end
            FN_SRLV: begin reg_form.op = XOP_SHR; reg_form.var_shift = 1'b1; end
            FN_SRAV: begin reg_form.op = XOP_SHA; reg_form.var_shift = 1'b1; end
            default: reg_form.bad = 1'b1;
        endcase
    end

    // immediate-form table, keyed on the opcode
    always_comb begin
        imm_form = '{op: XOP_NONE, bad: 1'b0, use_imm: 1'b1,
                     imm_sext: 1'b0, var_shift: 1'b0};
        case (opcode)
            OPC_ADDI, OPC_ADDIU: begin
                imm_form.op       = XOP_ADD;
                imm_form.imm_sext = 1'b1;
            end
            OPC_SLTI: begin
                imm_form.op       = XOP_LTS;
                imm_form.imm_sext = 1'b1;
            end
            OPC_ANDI: imm_form.op = XOP_AND;
            OPC_ORI:  imm_form.op = XOP_OR;
            OPC_XORI: imm_form.op = XOP_XOR;
            default: begin
                imm_form.bad     = 1'b1;
                imm_form.use_imm = 1'b0;
            end
        endcase
    end

    always_comb begin
        dec = (opcode == OPC_REG) ? reg_form : imm_form;
        if (dec.bad) begin
            dec.op = XOP_NONE;
        end
    end

endmodule

// File: rtl/iex_operand.sv
`timescale 1ns/1ps
module iex_operand
    import iex_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic [W-1:0]  rt_val,
    input  logic [IW-1:0] imm,
    input  logic          use_imm,
    input  logic          imm_sext,
    output logic [W-1:0]  b_opnd
);

    logic [W-1:0] imm_wide;

    generate
        if (W == DATA_W && IW == IMM_W) begin : g_pkg_ext
            assign imm_wide = widen_imm(imm, imm_sext);
        end else begin : g_gen_ext
            assign imm_wide = {{(W-IW){imm_sext & imm[IW-1]}}, imm};
        end
    endgenerate

    assign b_opnd = use_imm ? imm_wide : rt_val;

endmodule

// File: rtl/iex_shifter.sv
`timescale 1ns/1ps
module iex_shifter
    import iex_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int AW = SHAMT_W
) (
    input  logic [W-1:0]  src,
    input  logic [AW-1:0] amt,
    input  shk_e          kind,
    output logic [W-1:0]  dst
);

    localparam int STAGES = AW;

    logic [W-1:0] pre;
    logic [W-1:0] post;
    logic         fill;
    logic         left;
    logic [W-1:0] stage [STAGES+1];

    assign left = (kind == SHK_LEFT);
    assign fill = (kind == SHK_RARI) & src[W-1];

    // left shifts run through the right shifter on a mirrored word
    generate
        for (genvar i = 0; i < W; i++) begin : g_mirror
            assign pre[i]  = left ? src[W-1-i] : src[i];
            assign dst[i]  = left ? post[W-1-i] : post[i];
        end
    endgenerate

    assign stage[0] = pre;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            localparam int STEP = 1 << s;
            logic [W-1:0] moved;
            if (STEP < W) begin : g_part
                assign moved = {{STEP{fill}}, stage[s][W-1:STEP]};
            end else begin : g_all
                assign moved = {W{fill}};
            end
            assign stage[s+1] = amt[s] ? moved : stage[s];
        end
    endgenerate

    assign post = stage[STAGES];

endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
    import iex_pkg::*;
(
    input  logic [CODE_W-1:0]  opcode_i,
    input  logic [CODE_W-1:0]  funct_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [DATA_W-1:0]  rs_val_i,
    input  logic [DATA_W-1:0]  rt_val_i,
    input  logic [IMM_W-1:0]   imm_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               illegal_o
);

    xdec_t              dec;
    logic [DATA_W-1:0]  b_opnd;
    logic [SHAMT_W-1:0] sh_amt;
    logic [DATA_W-1:0]  sh_out;
    logic [DATA_W-1:0]  sum;
    logic [DATA_W-1:0]  diff;
    logic               lt_s;
    logic               lt_u;

    iex_decode u_dec (
        .opcode (opcode_i),
        .funct  (funct_i),
        .dec    (dec)
    );

    iex_operand #(.W(DATA_W), .IW(IMM_W)) u_opnd (
        .rt_val   (rt_val_i),
        .imm      (imm_i),
        .use_imm  (dec.use_imm),
        .imm_sext (dec.imm_sext),
        .b_opnd   (b_opnd)
    );

    assign sh_amt = dec.var_shift ? rs_val_i[SHAMT_W-1:0] : shamt_i;

    iex_shifter #(.W(DATA_W), .AW(SHAMT_W)) u_shf (
        .src  (rt_val_i),
        .amt  (sh_amt),
        .kind (shift_kind(dec.op)),
        .dst  (sh_out)
    );

    assign sum  = rs_val_i + b_opnd;
    assign diff = rs_val_i - b_opnd;
    assign lt_s = $signed(rs_val_i) < $signed(b_opnd);
    assign lt_u = rs_val_i < b_opnd;

    always_comb begin
        case (dec.op)
            XOP_ADD: result_o = sum;
            XOP_SUB: result_o = diff;
            XOP_AND: result_o = rs_val_i & b_opnd;
            XOP_OR:  result_o = rs_val_i | b_opnd;
            XOP_XOR: result_o = rs_val_i ^ b_opnd;
            XOP_NOR: result_o = ~(rs_val_i | b_opnd);
            XOP_LTS: result_o = {{(DATA_W-1){1'b0}}, lt_s};
            XOP_LTU: result_o = {{(DATA_W-1){1'b0}}, lt_u};
            XOP_SHL, XOP_SHR, XOP_SHA: result_o = sh_out;
            default: result_o = '0;
        endcase
    end

    assign illegal_o = dec.bad;

endmodule

// File: rtl/int_exec_unit_chk.sv
`timescale 1ns/1ps
module int_exec_unit_chk
    import iex_pkg::*;
(
    input logic [CODE_W-1:0]  opcode_i,
    input logic [CODE_W-1:0]  funct_i,
    input logic [SHAMT_W-1:0] shamt_i,
    input logic [DATA_W-1:0]  rs_val_i,
    input logic [DATA_W-1:0]  rt_val_i,
    input logic [IMM_W-1:0]   imm_i,
    input logic [DATA_W-1:0]  result_o,
    input logic               illegal_o
);

    logic known;
    logic is_reg;

    assign known  = !$isunknown({opcode_i, funct_i, shamt_i, rs_val_i,
                                 rt_val_i, imm_i, result_o, illegal_o});
    assign is_reg = (opcode_i == OPC_REG);

    always_comb begin
        if (known) begin
            AST_ILLEGAL_ZERO: assert (!illegal_o || result_o == '0); // R10
            AST_CMP_BOOL: assert (!((is_reg && (funct_i == FN_SLT || funct_i == FN_SLTU))
                                    || opcode_i == OPC_SLTI)
                                  || result_o[DATA_W-1:1] == '0); // R4
            AST_SLL_ZERO_COUNT: assert (!(is_reg && funct_i == FN_SLL && shamt_i == '0)
                                        || result_o == rt_val_i); // R6
            AST_SRL_TOP_CLEAR: assert (!(is_reg && funct_i == FN_SRL && shamt_i != '0)
                                       || !result_o[DATA_W-1]); // R6
            AST_SRA_KEEPS_SIGN: assert (!(is_reg && funct_i == FN_SRA)
                                        || result_o[DATA_W-1] == rt_val_i[DATA_W-1]); // R7
            AST_ANDI_UPPER_CLEAR: assert (opcode_i != OPC_ANDI
                                          || result_o[DATA_W-1:IMM_W] == '0); // R9
            AST_XORI_UPPER_PASS: assert (opcode_i != OPC_XORI
                                         || result_o[DATA_W-1:IMM_W] == rs_val_i[DATA_W-1:IMM_W]); // R9
            AST_ADDI_ZERO_IMM: assert (!(opcode_i == OPC_ADDI && imm_i == '0)
                                       || result_o == rs_val_i); // R1
        end
    end

endmodule

bind int_exec_unit int_exec_unit_chk u_chk (
    .opcode_i  (opcode_i),
    .funct_i   (funct_i),
    .shamt_i   (shamt_i),
    .rs_val_i  (rs_val_i),
    .rt_val_i  (rt_val_i),
    .imm_i     (imm_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode_i = '0;
    logic [5:0]  funct_i = '0;
    logic [4:0]  shamt_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [15:0] imm_i = '0;
    logic [31:0] result_o;
    logic        illegal_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit dut (
        .opcode_i  (opcode_i),
        .funct_i   (funct_i),
        .shamt_i   (shamt_i),
        .rs_val_i  (rs_val_i),
        .rt_val_i  (rt_val_i),
        .imm_i     (imm_i),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    // expected {illegal, result} built straight from the requirement list
    function automatic logic [32:0] expect_of(
        input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
        input logic [31:0] a, input logic [31:0] b, input logic [15:0] im
    );
        logic [31:0] sx;
        logic [31:0] zx;
        logic [31:0] r;
        logic        bad;
        sx  = {{16{im[15]}}, im};
        zx  = {16'h0000, im};
        r   = 32'h0;
        bad = 1'b0;
        if (op == 6'b000000) begin
            case (fn)
                6'b100000: r = a + b;
                6'b100010: r = a - b;
                6'b100100: r = a & b;
                6'b100101: r = a | b;
                6'b100110: r = a ^ b;
                6'b100111: r = ~(a | b);
                6'b101010: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                6'b101011: r = (a < b) ? 32'd1 : 32'd0;
                6'b000000: r = b << sh;
                6'b000010: r = b >> sh;
                6'b000011: r = 32'($signed(b) >>> sh);
                6'b000100: r = b << a[4:0];
                6'b000110: r = b >> a[4:0];
                6'b000111: r = 32'($signed(b) >>> a[4:0]);
                default:   bad = 1'b1;
            endcase
        end else begin
            case (op)
                6'b001000, 6'b001001: r = a + sx;
                6'b001010: r = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
                6'b001100: r = a & zx;
                6'b001101: r = a | zx;
                6'b001110: r = a ^ zx;
                default:   bad = 1'b1;
            endcase
        end
        return {bad, r};
    endfunction

    function automatic string tag_of(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'b000000) begin
            case (fn)
                6'b100000: return "R1";
                6'b100010: return "R2";
                6'b100100, 6'b100101, 6'b100110, 6'b100111: return "R3";
                6'b101010: return "R4";
                6'b101011: return "R5";
                6'b000000, 6'b000010: return "R6";
                6'b000011: return "R7";
                6'b000100, 6'b000110, 6'b000111: return "R8";
                default:   return "R10";
            endcase
        end
        case (op)
            6'b001000, 6'b001001: return "R1";
            6'b001010: return "R4";
            6'b001100, 6'b001101, 6'b001110: return "R9";
            default:   return "R10";
        endcase
    endfunction

    task automatic apply(
        input logic [5:0] op, input logic [5:0] fn, input logic [4:0] sh,
        input logic [31:0] a, input logic [31:0] b, input logic [15:0] im
    );
        logic [32:0] exp_v;
        @(negedge clk);
        opcode_i = op;
        funct_i  = fn;
        shamt_i  = sh;
        rs_val_i = a;
        rt_val_i = b;
        imm_i    = im;
        #1;
        exp_v = expect_of(op, fn, sh, a, b, im);
        n_vec++;
        if ({illegal_o, result_o} !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%b fn=%b: got flag=%b res=%h, expected flag=%b res=%h",
                     tag_of(op, fn), op, fn, illegal_o, result_o, exp_v[32], exp_v[31:0]);
        end
    endtask

    function automatic logic [5:0] legal_funct(input int k);
        case (k)
            0:  return 6'b100000;
            1:  return 6'b100010;
            2:  return 6'b100100;
            3:  return 6'b100101;
            4:  return 6'b100110;
            5:  return 6'b100111;
            6:  return 6'b101010;
            7:  return 6'b101011;
            8:  return 6'b000000;
            9:  return 6'b000010;
            10: return 6'b000011;
            11: return 6'b000100;
            12: return 6'b000110;
            default: return 6'b000111;
        endcase
    endfunction

    function automatic logic [5:0] legal_opcode(input int k);
        case (k)
            0: return 6'b001000;
            1: return 6'b001001;
            2: return 6'b001010;
            3: return 6'b001100;
            4: return 6'b001101;
            default: return 6'b001110;
        endcase
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom % 6)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1: register add with carry wrap, immediate adds with negative imm
        apply(6'b000000, 6'b100000, 5'd0, 32'hFFFF_FFFF, 32'h0000_0002, 16'h0);
        apply(6'b001000, 6'b000000, 5'd0, 32'h0000_0005, 32'h0, 16'hFFFF);
        apply(6'b001001, 6'b000000, 5'd0, 32'h0000_0010, 32'h0, 16'h8000);
        // R2: subtract order and wrap
        apply(6'b000000, 6'b100010, 5'd0, 32'h0000_0003, 32'h0000_0005, 16'h0);
        // R3: bitwise set on 0xF0 / 0x3C, NOR of a value with itself
        apply(6'b000000, 6'b100100, 5'd0, 32'hF0, 32'h3C, 16'h0);
        apply(6'b000000, 6'b100101, 5'd0, 32'hF0, 32'h3C, 16'h0);
        apply(6'b000000, 6'b100110, 5'd0, 32'hF0, 32'h3C, 16'h0);
        apply(6'b000000, 6'b100111, 5'd0, 32'hF0, 32'h3C, 16'h0);
        apply(6'b000000, 6'b100111, 5'd0, 32'hF0, 32'hF0, 16'h0);
        // R4: signed compares
        apply(6'b000000, 6'b101010, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h0);
        apply(6'b000000, 6'b101010, 5'd0, 32'hFF, 32'hFF, 16'h0);
        apply(6'b000000, 6'b101010, 5'd0, 32'hFF, 32'hFFFF_FFFF, 16'h0);
        apply(6'b001010, 6'b000000, 5'd0, 32'h0, 32'h0, 16'd35);
        apply(6'b001010, 6'b000000, 5'd0, 32'hFF, 32'h0, 16'hFFF9);
        // R5: unsigned compare reverses the sign-bit case
        apply(6'b000000, 6'b101011, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h0);
        apply(6'b000000, 6'b101011, 5'd0, 32'h0, 32'h8000_0000, 16'h0);
        // R6: immediate shifts, zero fill, count 0 and 31
        apply(6'b000000, 6'b000000, 5'd3, 32'h0, 32'h0000_000C, 16'h0);
        apply(6'b000000, 6'b000010, 5'd2, 32'h0, 32'h0000_000C, 16'h0);
        apply(6'b000000, 6'b000010, 5'd31, 32'h0, 32'h8000_0000, 16'h0);
        apply(6'b000000, 6'b000000, 5'd0, 32'h0, 32'hDEAD_BEEF, 16'h0);
        // R7: arithmetic right keeps sign
        apply(6'b000000, 6'b000011, 5'd2, 32'h0, 32'hFFFF_FFFC, 16'h0);
        apply(6'b000000, 6'b000011, 5'd31, 32'h0, 32'h8000_0001, 16'h0);
        apply(6'b000000, 6'b000011, 5'd0, 32'h0, 32'h8123_4567, 16'h0);
        // R8: variable shifts ignore rs upper bits and shamt
        apply(6'b000000, 6'b000100, 5'd17, 32'hFFFF_FFE5, 32'h0000_0001, 16'h0);
        apply(6'b000000, 6'b000110, 5'd9, 32'h1234_5660, 32'h8000_0000, 16'h0);
        apply(6'b000000, 6'b000111, 5'd1, 32'hFFFF_FFE4, 32'h8000_0000, 16'h0);
        // R9: zero-extended logical immediates
        apply(6'b001101, 6'b000000, 5'd0, 32'h0000_0000, 32'h0, 16'hFFFC);
        apply(6'b001100, 6'b000000, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001);
        apply(6'b001110, 6'b000000, 5'd0, 32'hFFFF_0000, 32'h0, 16'hFFFF);
        // R10: unlisted encodings
        apply(6'b000010, 6'b100000, 5'd0, 32'h1, 32'h2, 16'h3);
        apply(6'b000000, 6'b000001, 5'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0);
        apply(6'b000000, 6'b100001, 5'd0, 32'h1, 32'h1, 16'h0);
        apply(6'b001011, 6'b000000, 5'd0, 32'h1, 32'h1, 16'h5);

        // random mix: mostly legal encodings, some arbitrary fields
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] op;
            logic [5:0] fn;
            int sel;
            sel = int'($urandom % 10);
            if (sel < 6) begin
                op = 6'b000000;
                fn = legal_funct(int'($urandom % 14));
            end else if (sel < 9) begin
                op = legal_opcode(int'($urandom % 6));
                fn = 6'($urandom);
            end else begin
                op = 6'($urandom);
                fn = 6'($urandom);
            end
            apply(op, fn, 5'($urandom), pick_val(), pick_val(), 16'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion within 100000 cycles");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule